// File: doc/BRIEF.md
# Dual-Mode Maskable Interrupt Controller

This block collects sixteen maskable interrupt sources into a pending-flag register and chooses which one the CPU may take next. Fourteen sources are general-purpose request lines sampled on every clock. The other two are a data-log request and a real-time OS request, each raised by a one-cycle pulse from on-chip analysis logic. Software can also raise any group of flags in one write, which ORs a mask into the register. Two per-bit enable registers and a single global mask bit gate the pending flags.

Two eligibility rules exist, and the mode inputs pick one. In the standard rule a flag is serviceable when its normal enable bit is set and the global mask is clear; the debug enable register plays no part. While the CPU is in real-time emulation mode *and* halted, the rule changes: a flag needs its normal enable bit and its debug enable bit, and the global mask is ignored. Emulation mode with the CPU running uses the standard rule. Among eligible sources, the lowest bit index wins. The winner is offered on a valid/ready pair together with a 4-bit index.

The offer follows the valid/ready rules. `irq_valid` and `irq_index` are combinational views of the current state. While `irq_ready` stays low, nothing is consumed and every flag stays latched. The offer can change index if a higher-priority source becomes eligible. A transfer happens on any clock edge where both are high. That transfer clears the offered flag and sets the global mask, so the CPU is not offered a nested maskable interrupt.

Top module: `mint_ctrl`

## Requirements
- R1: After reset the pending flags read 0, both enable registers are 0, the global mask reads 1 and `irq_valid` is 0.
- R2: A high level on `ext_irq[k]` at a clock edge sets pending bit k (k = 0..13), and that bit stays set after the line returns low.
- R3: A pulse on `dlog_pulse` sets pending bit 14, and a pulse on `rtos_pulse` sets pending bit 15.
- R4: When `pend_or_we` is high, `pend_or_data` is ORed into the pending flags at the edge. Bits that are 0 in the data clear nothing.
- R5: `ien_we` loads `ien_data` into the enable register, and `dbg_ien_we` loads `dbg_ien_data` into the debug enable register. Bit k of each register belongs to pending bit k.
- R6: `gmask_set` makes the global mask 1 and `gmask_clr` makes it 0. If both strobes are high in the same cycle, the mask becomes 1.
- R7: When `rt_emu` and `cpu_halted` are not both high, source k is eligible only if pending[k], enable[k] and a global mask of 0 all hold. The debug enable bits have no effect in this case.
- R8: When `rt_emu` and `cpu_halted` are both high, source k is eligible only if pending[k], enable[k] and debug_enable[k] all hold. The global mask has no effect in this case.
- R9: `irq_valid` is high whenever any source is eligible. `irq_index` then gives the eligible source with the lowest bit number: general lines 0..13 first, then data-log (14), then real-time OS (15).
- R10: At an edge where `irq_valid` and `irq_ready` are both high, the pending bit named by `irq_index` is cleared, the other pending bits are kept, and the global mask becomes 1.
- R11: If the offered source's own raise (its line sample, pulse or OR write) is present at the accepting edge, its pending bit stays 1.
- R12: With `irq_ready` low, pending flags are never cleared and the global mask is not changed by the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq | input | 14 | General-purpose request lines, sampled every cycle |
| dlog_pulse | input | 1 | Data-log request pulse from analysis logic |
| rtos_pulse | input | 1 | Real-time OS request pulse from analysis logic |
| pend_or_we | input | 1 | OR-write strobe for pending flags |
| pend_or_data | input | 16 | Mask ORed into pending flags |
| ien_we | input | 1 | Enable register write strobe |
| ien_data | input | 16 | Enable register write data |
| dbg_ien_we | input | 1 | Debug enable register write strobe |
| dbg_ien_data | input | 16 | Debug enable register write data |
| gmask_set | input | 1 | Set global mask (disable all) |
| gmask_clr | input | 1 | Clear global mask (enable all) |
| rt_emu | input | 1 | CPU is in real-time emulation mode |
| cpu_halted | input | 1 | CPU is halted |
| irq_valid | output | 1 | An eligible interrupt is offered |
| irq_index | output | 4 | Bit number of the offered interrupt |
| irq_ready | input | 1 | CPU accepts the offered interrupt |
| pend_flags | output | 16 | Current pending flags |
| gmask | output | 1 | Current global mask |

## Verification
Every register input (line sample, pulse, OR write, enable write, mask strobe, acceptance) takes effect at the next rising edge. Its result shows on `pend_flags`, `gmask`, `irq_valid` and `irq_index` one edge after the stimulus. The mode inputs are purely combinational, so their effect is due in the same cycle. The bench drives inputs one time unit after a rising edge. It checks register results one time unit after the following edge, and it checks mode-only changes before any further edge.

// File: rtl/mint_pkg.sv
package mint_pkg;
  localparam int unsigned N_EXT_DEF = 14;
  localparam int unsigned N_SRC_DEF = N_EXT_DEF + 2;
  localparam int unsigned IDX_W_DEF = $clog2(N_SRC_DEF);

  typedef enum logic {
    RULE_STD = 1'b0,
    RULE_DBG = 1'b1
  } rule_e;
endpackage

// File: rtl/mint_flags.sv
module mint_flags #(
  parameter int unsigned N_EXT = mint_pkg::N_EXT_DEF,
  localparam int unsigned N_SRC = N_EXT + 2,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_irq,
  input  logic             dlog_pulse,
  input  logic             rtos_pulse,
  input  logic             set_we,
  input  logic [N_SRC-1:0] set_data,
  input  logic             clr_fire,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [N_SRC-1:0] pend_q
);
  logic [N_SRC-1:0] raise;
  logic [N_SRC-1:0] drop;

  always_comb begin
    raise = {rtos_pulse, dlog_pulse, ext_irq};
    if (set_we) raise = raise | set_data;
    drop = '0;
    if (clr_fire) drop[clr_idx] = 1'b1;
  end

  // A raise in the same cycle beats the clear.
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~drop) | raise;
  end

  assert_line_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|ext_irq) |=> ((pend_q[N_EXT-1:0] & $past(ext_irq)) == $past(ext_irq)));
  assert_dlog_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dlog_pulse |=> pend_q[N_EXT]);
  assert_rtos_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rtos_pulse |=> pend_q[N_EXT+1]);
  assert_or_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((pend_q & $past(set_data)) == $past(set_data)));
  assert_ack_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fire && !raise[clr_idx]) |=> !pend_q[$past(clr_idx)]);
  assert_raise_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fire && raise[clr_idx]) |=> pend_q[$past(clr_idx)]);
  assert_no_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_fire |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/mint_enables.sv
module mint_enables #(
  parameter int unsigned N_SRC = mint_pkg::N_SRC_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ien_we,
  input  logic [N_SRC-1:0] ien_data,
  input  logic             dbg_we,
  input  logic [N_SRC-1:0] dbg_data,
  input  logic             gmask_set,
  input  logic             gmask_clr,
  input  logic             ack_fire,
  output logic [N_SRC-1:0] ien_q,
  output logic [N_SRC-1:0] dbg_q,
  output logic             gmask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q   <= '0;
      dbg_q   <= '0;
      gmask_q <= 1'b1;
    end else begin
      if (ien_we) ien_q <= ien_data;
      if (dbg_we) dbg_q <= dbg_data;
      if (gmask_set || ack_fire) gmask_q <= 1'b1;
      else if (gmask_clr)        gmask_q <= 1'b0;
    end
  end

  assert_mask_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gmask_set |=> gmask_q);
  assert_mask_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gmask_clr && !gmask_set && !ack_fire) |=> !gmask_q);
  assert_ack_masks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> gmask_q);
  assert_mask_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_fire && !gmask_set && !gmask_clr) |=> $stable(gmask_q));
endmodule

// File: rtl/mint_select.sv
module mint_select #(
  parameter int unsigned N_SRC = mint_pkg::N_SRC_DEF,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] pend,
  input  logic [N_SRC-1:0] ien,
  input  logic [N_SRC-1:0] dbg,
  input  logic             gmask,
  input  logic             rt_emu,
  input  logic             cpu_halted,
  output logic             valid,
  output logic [IDX_W-1:0] idx
);
  import mint_pkg::*;

  rule_e            rule;
  logic [N_SRC-1:0] gate;
  logic [N_SRC-1:0] elig;

  always_comb begin
    rule = (rt_emu && cpu_halted) ? RULE_DBG : RULE_STD;
    if (rule == RULE_DBG) gate = dbg;
    else                  gate = gmask ? '0 : '1;
    elig  = pend & ien & gate;
    valid = |elig;
    idx   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i]) idx = IDX_W'(i);
    end
  end

  assert_offer_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (pend[idx] && ien[idx]));
  assert_std_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !(rt_emu && cpu_halted)) |-> !gmask);
  assert_dbg_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && rt_emu && cpu_halted) |-> dbg[idx]);
endmodule

// File: rtl/mint_ctrl.sv
module mint_ctrl #(
  parameter int unsigned N_EXT = mint_pkg::N_EXT_DEF,
  localparam int unsigned N_SRC = N_EXT + 2,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_irq,
  input  logic             dlog_pulse,
  input  logic             rtos_pulse,
  input  logic             pend_or_we,
  input  logic [N_SRC-1:0] pend_or_data,
  input  logic             ien_we,
  input  logic [N_SRC-1:0] ien_data,
  input  logic             dbg_ien_we,
  input  logic [N_SRC-1:0] dbg_ien_data,
  input  logic             gmask_set,
  input  logic             gmask_clr,
  input  logic             rt_emu,
  input  logic             cpu_halted,
  output logic             irq_valid,
  output logic [IDX_W-1:0] irq_index,
  input  logic             irq_ready,
  output logic [N_SRC-1:0] pend_flags,
  output logic             gmask
);
  logic [N_SRC-1:0] ien_q;
  logic [N_SRC-1:0] dbg_q;
  logic             ack_fire;

  assign ack_fire = irq_valid && irq_ready;

  mint_flags #(.N_EXT(N_EXT)) u_flags (
    .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq),
    .dlog_pulse(dlog_pulse), .rtos_pulse(rtos_pulse),
    .set_we(pend_or_we), .set_data(pend_or_data),
    .clr_fire(ack_fire), .clr_idx(irq_index), .pend_q(pend_flags)
  );

  mint_enables #(.N_SRC(N_SRC)) u_enables (
    .clk(clk), .rst_n(rst_n),
    .ien_we(ien_we), .ien_data(ien_data),
    .dbg_we(dbg_ien_we), .dbg_data(dbg_ien_data),
    .gmask_set(gmask_set), .gmask_clr(gmask_clr), .ack_fire(ack_fire),
    .ien_q(ien_q), .dbg_q(dbg_q), .gmask_q(gmask)
  );

  mint_select #(.N_SRC(N_SRC)) u_select (
    .clk(clk), .rst_n(rst_n), .pend(pend_flags), .ien(ien_q), .dbg(dbg_q),
    .gmask(gmask), .rt_emu(rt_emu), .cpu_halted(cpu_halted),
    .valid(irq_valid), .idx(irq_index)
  );
endmodule

// File: tb/mint_ctrl_tb.sv
module mint_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] ext_irq;
  logic        dlog_pulse, rtos_pulse;
  logic        pend_or_we;
  logic [15:0] pend_or_data;
  logic        ien_we, dbg_ien_we;
  logic [15:0] ien_data, dbg_ien_data;
  logic        gmask_set, gmask_clr;
  logic        rt_emu, cpu_halted;
  logic        irq_valid;
  logic [3:0]  irq_index;
  logic        irq_ready;
  logic [15:0] pend_flags;
  logic        gmask;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  mint_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq),
    .dlog_pulse(dlog_pulse), .rtos_pulse(rtos_pulse),
    .pend_or_we(pend_or_we), .pend_or_data(pend_or_data),
    .ien_we(ien_we), .ien_data(ien_data),
    .dbg_ien_we(dbg_ien_we), .dbg_ien_data(dbg_ien_data),
    .gmask_set(gmask_set), .gmask_clr(gmask_clr),
    .rt_emu(rt_emu), .cpu_halted(cpu_halted),
    .irq_valid(irq_valid), .irq_index(irq_index), .irq_ready(irq_ready),
    .pend_flags(pend_flags), .gmask(gmask)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    ext_irq = '0; dlog_pulse = 0; rtos_pulse = 0;
    pend_or_we = 0; pend_or_data = '0;
    ien_we = 0; ien_data = '0; dbg_ien_we = 0; dbg_ien_data = '0;
    gmask_set = 0; gmask_clr = 0; irq_ready = 0;
  endtask

  task automatic do_reset();
    idle();
    rt_emu = 0; cpu_halted = 0;
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
    tick();
  endtask

  // Load pending OR, enables and optionally clear the mask in one edge.
  task automatic setup(input logic [15:0] p, input logic [15:0] en,
                       input logic [15:0] den, input logic unmask);
    pend_or_we = 1; pend_or_data = p;
    ien_we = 1; ien_data = en;
    dbg_ien_we = 1; dbg_ien_data = den;
    gmask_clr = unmask;
    tick();
    idle();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 pend", pend_flags, 16'h0);
    chk("R1 gmask", gmask, 1);
    chk("R1 valid", irq_valid, 0);
    // Enables are zero: a flag with unmasked gate still gives no offer.
    setup(16'h0001, 16'h0000, 16'h0000, 1);
    chk("R1 enable zero", irq_valid, 0);
  endtask

  task automatic t_line_latch();
    do_reset();
    ext_irq[3] = 1; ext_irq[13] = 1;
    tick();
    idle();
    chk("R2 latch", pend_flags, 16'h2008);
    tick(); tick();
    chk("R2 held", pend_flags, 16'h2008);
  endtask

  task automatic t_analysis();
    do_reset();
    dlog_pulse = 1;
    tick();
    idle();
    chk("R3 dlog", pend_flags, 16'h4000);
    rtos_pulse = 1;
    tick();
    idle();
    chk("R3 rtos", pend_flags, 16'hC000);
  endtask

  task automatic t_or_write();
    do_reset();
    pend_or_we = 1; pend_or_data = 16'h0101;
    tick();
    pend_or_data = 16'h8000;
    tick();
    idle();
    chk("R4 or accumulate", pend_flags, 16'h8101);
  endtask

  task automatic t_std_rule();
    do_reset();
    setup(16'h0020, 16'h0020, 16'h0000, 1);
    chk("R5 R7 valid", irq_valid, 1);
    chk("R7 index", irq_index, 5);
    rt_emu = 1; #1;
    chk("R7 emu running", irq_valid, 1);
    gmask_set = 1; gmask_clr = 1;
    tick();
    idle();
    chk("R6 both strobes", gmask, 1);
    chk("R7 masked", irq_valid, 0);
    gmask_clr = 1;
    tick();
    idle();
    chk("R6 clr", gmask, 0);
    ien_we = 1; ien_data = 16'h0000;
    tick();
    idle();
    chk("R5 ien rewrite", irq_valid, 0);
    rt_emu = 0;
  endtask

  task automatic t_dbg_rule();
    do_reset();
    setup(16'h0020, 16'h0020, 16'h0000, 0);
    rt_emu = 1; cpu_halted = 1; #1;
    chk("R8 no dbg enable", irq_valid, 0);
    dbg_ien_we = 1; dbg_ien_data = 16'h0020;
    tick();
    idle();
    chk("R8 mask ignored", irq_valid, 1);
    chk("R8 index", irq_index, 5);
    cpu_halted = 0; #1;
    chk("R7 running masked", irq_valid, 0);
    rt_emu = 0;
  endtask

  task automatic t_priority();
    do_reset();
    setup(16'hC204, 16'hFFFF, 16'h0000, 1);
    chk("R9 first", irq_index, 2);
    irq_ready = 1;
    tick();
    irq_ready = 0;
    chk("R10 clear", pend_flags, 16'hC200);
    chk("R10 mask", gmask, 1);
    chk("R10 no offer", irq_valid, 0);
    gmask_clr = 1; tick(); idle();
    chk("R9 second", irq_index, 9);
    irq_ready = 1; tick(); idle();
    gmask_clr = 1; tick(); idle();
    chk("R9 dlog", irq_index, 14);
    irq_ready = 1; tick(); idle();
    gmask_clr = 1; tick(); idle();
    chk("R9 rtos", irq_index, 15);
    irq_ready = 1; tick(); idle();
    chk("R10 empty", pend_flags, 16'h0);
  endtask

  task automatic t_hold();
    do_reset();
    setup(16'h0820, 16'h0820, 16'h0000, 1);
    tick(); tick(); tick();
    chk("R12 pend kept", pend_flags, 16'h0820);
    chk("R12 mask kept", gmask, 0);
    chk("R12 still offered", irq_index, 5);
  endtask

  task automatic t_collision();
    do_reset();
    setup(16'h0004, 16'hFFFF, 16'h0000, 1);
    irq_ready = 1; ext_irq[2] = 1;
    tick();
    idle();
    chk("R11 raise wins", pend_flags, 16'h0004);
    chk("R11 mask", gmask, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_line_latch();
    t_analysis();
    t_or_write();
    t_std_rule();
    t_dbg_rule();
    t_priority();
    t_hold();
    t_collision();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule